// File: doc/BRIEF.md
# ADC Conversion Trigger and Timing Controller

This block controls when a 12-bit successive-approximation converter samples and converts. A three-bit select picks one of eight start sources. Seven of them are hardware trigger inputs. The eighth is a software request bit, which a one-cycle pulse sets. A conversion starts only on a rising edge of the selected hardware input. The hardware inputs pass through a two-stage synchroniser before edge detection, so the start latency is fixed.

The block runs on a clock at twice the converter clock, so each `clk` cycle is half a converter cycle. This makes the fractional phase lengths exact. The sampling phase length comes from a per-channel sample-time code. A fixed conversion phase of 12.5 converter cycles follows it. The block drives `sample_en` and `convert_en` over those phases. The analog result arrives on `result_in`. At the end of conversion the block packs that result into a 16-bit word, aligned right or left, and raises a one-cycle `eoc` pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion starts on a rising edge of the selected hardware input. `sample_en` is first high after the third rising `clk` edge following the input's rise. Holding the input high does not start another conversion.
- R2: `trig_sel` values 0 to 6 select `trig_hw[trig_sel]`. Edges on inputs that are not selected start nothing.
- R3: `trig_sel` = 7 selects the software request. A `sw_start_set` pulse sets the request, and `sample_en` is first high after the second rising edge from the pulse. The request clears when the conversion begins, so one pulse gives exactly one conversion.
- R4: `sample_en` stays high for 2×S `clk` cycles. S is the sample time in converter cycles for the code in `smp_codes[3*ch_sel +: 3]`, taken when the conversion starts. Codes 0 to 7 give S = 1.5, 7.5, 13.5, 28.5, 41.5, 55.5, 71.5 and 239.5.
- R5: `convert_en` goes high in the cycle after `sample_en` falls and stays high for 25 `clk` cycles (12.5 converter cycles). With code 0, sampling plus conversion lasts 28 `clk` cycles, which is 14 converter cycles.
- R6: `eoc` is high for exactly one cycle, the cycle after `convert_en` falls. `data_out` takes the new result in that same cycle, from `result_in` as it was during the last conversion cycle.
- R7: With `align_left` = 0, `data_out` = {4'b0, result}. With `align_left` = 1, `data_out` = {result, 4'b0}.
- R8: `data_out` holds its value until the next `eoc`, whatever `result_in` and `align_left` do in between.
- R9: Hardware edges that arrive while a conversion is in progress are ignored. This covers the sampling, conversion and store cycles.
- R10: A software request set while a conversion is in progress stays pending. `sample_en` rises two cycles after that conversion's `eoc`.
- R11: Synchronous reset (`rst` = 1) returns the block to idle. It drives all strobes low, clears `data_out` to 0 and drops any pending software request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock rate |
| rst | input | 1 | Synchronous reset, active high |
| trig_hw | input | 7 | Hardware trigger inputs, asynchronous |
| sw_start_set | input | 1 | One-cycle pulse that sets the software request |
| trig_sel | input | 3 | Start source select (7 = software) |
| smp_codes | input | 12 | Packed 3-bit sample-time codes, one per channel |
| ch_sel | input | 2 | Channel whose sample-time code is used |
| align_left | input | 1 | 1 = left-aligned result word |
| result_in | input | 12 | Conversion result from the analog side |
| sample_en | output | 1 | High during the sampling phase |
| convert_en | output | 1 | High during the conversion phase |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| data_out | output | 16 | Packed result word |

## Verification
The table-driven pass covers every select value with a different sample-time code. Each vector uses its own channel, and the other channels hold different codes, so a wrong channel index or a wrong code table gives a different `sample_en` length. Alignment alternates across the vectors. The results include all-ones, one lone high bit and one lone low bit, which separates left from right packing and exposes any stray padding bits. Directed tests cover the following: edges on unselected inputs, a held-high level, a retrigger during sampling, a software request queued behind a running conversion, result changes after `eoc`, and reset in the middle of a conversion with a request pending.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int SEL_W  = 3;
  localparam int SMP_W  = 3;
  localparam int RES_W  = 12;
  localparam int WORD_W = 16;
  localparam int PAD_W  = WORD_W - RES_W;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2,
    ST_STORE   = 2'd3
  } seq_state_e;

  // Sampling length in half converter cycles (twice the cycle count).
  function automatic int unsigned smp_half_cycles(input logic [SMP_W-1:0] code);
    case (code)
      3'd0:    return 3;
      3'd1:    return 15;
      3'd2:    return 27;
      3'd3:    return 57;
      3'd4:    return 83;
      3'd5:    return 111;
      3'd6:    return 143;
      default: return 479;
    endcase
  endfunction

  // Conversion phase: one half cycle per bit, twice, plus one half cycle.
  function automatic int unsigned conv_half_cycles(input int unsigned res_bits);
    return 2 * res_bits + 1;
  endfunction

  function automatic logic [WORD_W-1:0] pack_result(input logic [RES_W-1:0] r,
                                                    input logic left);
    if (left) return {r, {PAD_W{1'b0}}};
    else      return {{PAD_W{1'b0}}, r};
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] trig_in,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= trig_in[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign rise[i] = s2_q & ~s3_q;

    // R1: an edge yields a single-cycle pulse, never a level
    p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end

endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

  // R4: a running count drops by exactly one per cycle
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              align_left,
  input  logic [RES_W-1:0]  res_in,
  output logic [WORD_W-1:0] data_out,
  output logic              eoc
);

  logic [WORD_W-1:0] data_q;
  logic              eoc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      eoc_q  <= 1'b0;
    end else begin
      eoc_q <= capture;
      if (capture) data_q <= pack_result(res_in, align_left);
    end
  end

  assign data_out = data_q;
  assign eoc      = eoc_q;

  // R6: end-of-conversion lasts one cycle
  p_eoc_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);

  // R8: the word only moves together with eoc
  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!eoc && !$past(rst)) |-> $stable(data_out));

  // R7: padding bits sit on the side chosen at capture
  p_align_pad_r7: assert property (@(posedge clk) disable iff (rst)
    eoc |-> ($past(align_left) ? (data_out[PAD_W-1:0] == '0)
                               : (data_out[WORD_W-1:RES_W] == '0)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_HW = 7,
  parameter int NUM_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_HW-1:0]         trig_hw,
  input  logic                      sw_start_set,
  input  logic [SEL_W-1:0]          trig_sel,
  input  logic [NUM_CH*SMP_W-1:0]   smp_codes,
  input  logic [$clog2(NUM_CH)-1:0] ch_sel,
  input  logic                      align_left,
  input  logic [RES_W-1:0]          result_in,
  output logic                      sample_en,
  output logic                      convert_en,
  output logic                      eoc,
  output logic [WORD_W-1:0]         data_out
);

  localparam int          MAX_HALF  = smp_half_cycles(3'd7);
  localparam int          CNT_W     = $clog2(MAX_HALF);
  localparam int unsigned CONV_HALF = conv_half_cycles(RES_W);
  localparam logic [SEL_W-1:0] SW_CODE = SEL_W'(NUM_HW);

  seq_state_e state_q, state_d;

  logic [NUM_HW-1:0] hw_rise;
  logic              sel_rise;
  logic              sw_pend_q;
  logic              start_req;
  logic              start_fire;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expire;
  logic              capture;
  logic [SMP_W-1:0]  cur_code;
  logic [CNT_W-1:0]  smp_load;

  adc_trig_sync #(.N(NUM_HW)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .trig_in (trig_hw),
    .rise    (hw_rise)
  );

  always_comb begin
    sel_rise = 1'b0;
    for (int i = 0; i < NUM_HW; i++)
      if (trig_sel == SEL_W'(i)) sel_rise = hw_rise[i];
  end

  assign start_req  = (trig_sel == SW_CODE) ? sw_pend_q : sel_rise;
  assign start_fire = (state_q == ST_IDLE) && start_req;

  always_ff @(posedge clk) begin
    if (rst)                                       sw_pend_q <= 1'b0;
    else if (sw_start_set)                         sw_pend_q <= 1'b1;
    else if (start_fire && trig_sel == SW_CODE)    sw_pend_q <= 1'b0;
  end

  assign cur_code = smp_codes[int'(ch_sel)*SMP_W +: SMP_W];
  assign smp_load = CNT_W'(smp_half_cycles(cur_code) - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_req) begin
        state_d  = ST_SAMPLE;
        tmr_load = 1'b1;
        tmr_val  = smp_load;
      end
      ST_SAMPLE: if (tmr_expire) begin
        state_d  = ST_CONVERT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(CONV_HALF - 1);
      end
      ST_CONVERT: if (tmr_expire) begin
        state_d = ST_STORE;
        capture = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  adc_result_reg u_result (
    .clk        (clk),
    .rst        (rst),
    .capture    (capture),
    .align_left (align_left),
    .res_in     (result_in),
    .data_out   (data_out),
    .eoc        (eoc)
  );

  assign sample_en  = (state_q == ST_SAMPLE);
  assign convert_en = (state_q == ST_CONVERT);

  // Checker-side run length of the conversion phase
  logic [CNT_W-1:0] conv_run_q;
  always_ff @(posedge clk) begin
    if (rst)             conv_run_q <= '0;
    else if (convert_en) conv_run_q <= conv_run_q + 1'b1;
    else                 conv_run_q <= '0;
  end

  // R5: conversion follows sampling immediately
  p_sample_then_convert_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sample_en) |-> convert_en);

  // R5: conversion phase spans the fixed half-cycle count
  p_conv_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(convert_en) |-> (conv_run_q == CNT_W'(CONV_HALF)));

  // R6: end-of-conversion directly after the conversion phase
  p_convert_then_eoc_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(convert_en) |-> eoc);

  // R9: sampling only ever begins from idle
  p_start_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_en) |-> ($past(state_q) == ST_IDLE));

  // R3: the software request is consumed by its conversion
  p_sw_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (start_fire && trig_sel == SW_CODE && !sw_start_set) |=> !sw_pend_q);

endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  trig_hw;
  logic        sw_start_set;
  logic [2:0]  trig_sel;
  logic [11:0] smp_codes;
  logic [1:0]  ch_sel;
  logic        align_left;
  logic [11:0] result_in;
  logic        sample_en, convert_en, eoc;
  logic [15:0] data_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst(rst), .trig_hw(trig_hw), .sw_start_set(sw_start_set),
    .trig_sel(trig_sel), .smp_codes(smp_codes), .ch_sel(ch_sel),
    .align_left(align_left), .result_in(result_in), .sample_en(sample_en),
    .convert_en(convert_en), .eoc(eoc), .data_out(data_out)
  );

  localparam int NV = 8;
  localparam int V_SEL  [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int V_CODE [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int V_CH   [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int V_ALN  [NV] = '{0, 1, 0, 1, 0, 1, 1, 0};
  localparam int V_RES  [NV] = '{'hABC, 'h5A5, 'hFFF, 'hFFF, 'h001, 'h800, 'h123, 'h7E1};
  // sample times in tenths of a converter cycle
  localparam int TENTHS [8]  = '{15, 75, 135, 285, 415, 555, 715, 2395};

  task automatic check(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic no_start(input int cycles, input string req, input string what);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      tick();
      if (sample_en) seen = 1;
    end
    check(seen, 0, req, what);
  endtask

  // Fire, then time the phases of one conversion and check its word
  task automatic run_conv(input int sel, input int code, input int ch,
                          input int aln, input int res, input string tag);
    int lat, ns, nc;
    int exp_data;
    trig_sel   = 3'(sel);
    ch_sel     = 2'(ch);
    align_left = aln[0];
    result_in  = 12'(res);
    for (int c = 0; c < 4; c++) smp_codes[c*3 +: 3] = 3'(code ^ 5);
    smp_codes[ch*3 +: 3] = 3'(code);
    lat = 0;
    if (sel == 7) begin
      sw_start_set = 1'b1;
      tick();
      sw_start_set = 1'b0;
      lat = 1;
    end else begin
      trig_hw[sel] = 1'b1;
    end
    while (!sample_en && lat < 12) begin tick(); lat++; end
    check(lat, (sel == 7) ? 2 : 3, (sel == 7) ? "R3" : "R1", {tag, " start latency"});
    ns = 0;
    while (sample_en && ns < 600) begin ns++; tick(); end
    check(ns, TENTHS[code] / 5, "R4", {tag, " sample cycles"});
    nc = 0;
    while (convert_en && nc < 60) begin nc++; tick(); end
    check(nc, 25, "R5", {tag, " convert cycles"});
    exp_data = aln ? (res * 16) : res;
    check(int'(eoc), 1, "R6", {tag, " eoc after convert"});
    check(int'(data_out), exp_data, "R7", {tag, " packed word"});
    tick();
    check(int'(eoc), 0, "R6", {tag, " eoc single cycle"});
    if (sel != 7) trig_hw[sel] = 1'b0;
    tick(); tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] held;
    rst = 1'b1; trig_hw = '0; sw_start_set = 1'b0; trig_sel = '0;
    smp_codes = '0; ch_sel = '0; align_left = 1'b0; result_in = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    check(int'({sample_en, convert_en, eoc}), 0, "R11", "strobes after reset");
    check(int'(data_out), 0, "R11", "data after reset");

    // table walk: every source, every sample code
    for (int v = 0; v < NV; v++)
      run_conv(V_SEL[v], V_CODE[v], V_CH[v], V_ALN[v], V_RES[v], $sformatf("vec%0d", v));

    // R5 total time with code 0 is 28 half cycles: covered by vec0 (3+25)
    // R1: held-high level does not restart
    trig_sel = 3'd0; smp_codes = '0; ch_sel = 2'd0;
    trig_hw[0] = 1'b1;
    while (!sample_en) tick();
    while (!eoc) tick();
    no_start(30, "R1", "held level restarts");
    trig_hw[0] = 1'b0; tick(); tick();

    // R2: unselected inputs start nothing
    trig_sel = 3'd2;
    trig_hw = 7'b1111011;
    no_start(20, "R2", "unselected input started");
    trig_hw = '0; tick(); tick();

    // R9: edge during sampling is ignored
    trig_sel = 3'd0; smp_codes[2:0] = 3'd3;
    trig_hw[0] = 1'b1;
    while (!sample_en) tick();
    trig_hw[0] = 1'b0; tick(); tick();
    trig_hw[0] = 1'b1;
    while (!eoc) tick();
    no_start(40, "R9", "edge while busy started");
    trig_hw[0] = 1'b0; tick(); tick();

    // R8: word holds after eoc
    held = data_out;
    result_in = 12'h3C3; align_left = ~align_left;
    repeat (20) tick();
    check(int'(data_out), int'(held), "R8", "word held");

    // R10: software request queued behind a running conversion
    trig_sel = 3'd7; smp_codes[2:0] = 3'd1; align_left = 1'b0; result_in = 12'h0F0;
    sw_start_set = 1'b1; tick(); sw_start_set = 1'b0;
    while (!sample_en) tick();
    tick();
    sw_start_set = 1'b1; tick(); sw_start_set = 1'b0;
    while (!eoc) tick();
    check(int'(data_out), 'h0F0, "R7", "right aligned word");
    tick();
    check(int'(sample_en), 0, "R10", "idle after store");
    tick();
    check(int'(sample_en), 1, "R10", "queued request started");
    while (!eoc) tick();
    // R3: one pulse, one conversion
    no_start(40, "R3", "request not cleared");

    // R11: reset mid-conversion with request pending
    sw_start_set = 1'b1; tick(); sw_start_set = 1'b0;
    while (!sample_en) tick();
    sw_start_set = 1'b1; tick(); sw_start_set = 1'b0;
    rst = 1'b1;
    repeat (3) tick();
    check(int'({sample_en, convert_en, eoc}), 0, "R11", "strobes in reset");
    check(int'(data_out), 0, "R11", "data cleared");
    rst = 1'b0;
    no_start(40, "R11", "pending request survived reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule